// File: doc/BRIEF.md
# 1-Wire Serial Identity Responder

This block is a synchronous model of a slave that holds only a fixed 64-bit identity and serves it over a single-wire, open-drain bus. The bus level arrives on `bus_i`, which passes through a flop synchroniser. The block pulls the line low by raising `bus_pull_o`. An external buffer turns that signal into an open-drain driver, and a pull-up holds the line high at all other times. Every bus time is measured in whole microseconds. A tick derived from the system clock through the `CLK_PER_US` parameter provides that count.

The identity is built from three parameters, packed as `{CRC, SERIAL, FAMILY}`: a family byte (default 01h) in bits 7:0, a 48-bit serial number in bits 55:8, and a check byte in bits 63:56. A long low on the line resets the block, and the block answers with a presence pulse. It then shifts in an 8-bit command. It either streams its identity, joins a bitwise search arbitration, or goes quiet until the next bus reset.

Top module: `ow_serial_id`

## Requirements
- R1: A low on the synchronised line lasting at least `RESET_US` (480) µs, followed by a return to high, is a bus reset. Shorter lows (write slots, or a 200 µs low) never start a presence pulse.
- R2: After a bus reset ends, `bus_pull_o` stays low for `PDH_US` (30) µs. It is then high for `PDL_US` (120) µs as the presence pulse, and low again afterwards.
- R3: After presence, the block takes 8 write slots as a command, least significant bit first. Each slot starts on a falling edge of the line. The level is sampled `SAMPLE_US` (30) µs after the edge, so a 1–15 µs low reads as 1 and a 60–120 µs low reads as 0. `bus_pull_o` stays low in every write slot.
- R4: Command 33h or 0Fh starts a read of 64 slots. Slot i returns identity bit i, so the family byte goes first (bit 0 first) and the check byte goes last. A 0 is sent by pulling the line for `HOLD_US` (15) µs from the slot's falling edge. A 1 is sent by leaving the line released. After bit 63 the block stays released until a bus reset.
- R5: Command F0h starts a search. For each identity bit i from 0 to 63, the block sends bit i in one read slot and its complement in the next, then samples one write slot. If the written bit differs from bit i, the block stays released until a bus reset. The block also stays released once bit 63 has been accepted.
- R6: Command 55h, command CCh, and every command other than 33h, 0Fh and F0h leave `bus_pull_o` low until the next bus reset.
- R7: `bus_pull_o` is high only during a presence pulse or during the first `HOLD_US` µs of a read slot that sends 0.
- R8: A bus reset in any state aborts the transaction in progress and restarts the presence sequence.
- R9: While `rst_n` is low and after its release, `bus_pull_o` is low. The block ignores read slots until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Level of the shared bus line, asynchronous |
| bus_pull_o | output | 1 | High to pull the bus line low |

## Verification
The identity is read back in full under both read opcodes. A read is also cut short by a bus reset and restarted, which separates a correct abort from a block that resumes where it stopped. A complete search, with every written bit matching, shows the true-then-complement order across all 64 bits. A second search writes a wrong bit at position 10, which shows that the block drops out at exactly that bit. Rejected opcodes, a 200 µs low and read slots before the first reset show that the line stays released when nothing should answer.

// File: rtl/ow_id_pkg.sv
`timescale 1ns/1ps
package ow_id_pkg;

   typedef enum logic [2:0] {
      ST_SILENT,
      ST_PWAIT,
      ST_PDRV,
      ST_CMD,
      ST_READ,
      ST_SBIT,
      ST_SCMP,
      ST_SWR
   } ow_state_e;

   localparam logic [7:0] OP_READ_A = 8'h33;
   localparam logic [7:0] OP_READ_B = 8'h0F;
   localparam logic [7:0] OP_SEARCH = 8'hF0;

endpackage

// File: rtl/ow_sync.sv
`timescale 1ns/1ps
module ow_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ow_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ow_us_tick.sv
`timescale 1ns/1ps
module ow_us_tick #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   if (CLK_PER_US < 1) begin : g_bad_div
      $error("ow_us_tick: CLK_PER_US must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign tick_o = (cnt == CW'(CLK_PER_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (tick_o) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   if (CLK_PER_US > 1) begin : g_gap_chk
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o); // R2
   end

endmodule

// File: rtl/ow_low_watch.sv
`timescale 1ns/1ps
module ow_low_watch #(
   parameter int RESET_US = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic line_i,
   output logic rst_det_o
);

   localparam int LW = $clog2(RESET_US + 1);

   logic [LW-1:0] low_us;
   logic          line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_us    <= '0;
         line_q    <= 1'b1;
         rst_det_o <= 1'b0;
      end else begin
         line_q    <= line_i;
         rst_det_o <= 1'b0;
         if (!line_i) begin
            if (tick_i && low_us != LW'(RESET_US)) low_us <= low_us + 1'b1;
         end else begin
            low_us <= '0;
            if (!line_q && low_us == LW'(RESET_US)) rst_det_o <= 1'b1;
         end
      end
   end

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_det_o |=> !rst_det_o); // R1

endmodule

// File: rtl/ow_serial_id.sv
`timescale 1ns/1ps
module ow_serial_id
   import ow_id_pkg::*;
#(
   parameter int          CLK_PER_US  = 50,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  FAMILY      = 8'h01,
   parameter logic [47:0] SERIAL      = 48'h0000_1234_5678,
   parameter logic [7:0]  CRC         = 8'h00,
   parameter int          RESET_US    = 480,
   parameter int          PDH_US      = 30,
   parameter int          PDL_US      = 120,
   parameter int          SAMPLE_US   = 30,
   parameter int          HOLD_US     = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_i,
   output logic bus_pull_o
);

   localparam logic [63:0] ID   = {CRC, SERIAL, FAMILY};
   localparam int          TMAX = (PDL_US > SAMPLE_US) ? PDL_US : SAMPLE_US;
   localparam int          TW   = $clog2(TMAX + 1) + 1;

   if (PDH_US < 15 || PDH_US > 60 || PDL_US < 60 || PDL_US > 240 ||
       SAMPLE_US < 15 || SAMPLE_US > 60 || HOLD_US < 1 ||
       HOLD_US >= SAMPLE_US || RESET_US < 121) begin : g_bad_timing
      $error("ow_serial_id: bus timing parameters out of range");
   end

   logic          bus_s, bus_q, fall, tick, rst_det;
   ow_state_e     state;
   logic [TW-1:0] tmr;
   logic          in_slot;
   logic [5:0]    bit_idx;
   logic [6:0]    cmd;
   logic          cur, send_bit, sending;

   ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s));

   ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   ow_low_watch #(.RESET_US(RESET_US)) u_low (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(bus_s),
      .rst_det_o(rst_det));

   assign fall = bus_q & ~bus_s;
   assign cur  = ID[bit_idx];

   always_comb begin
      sending  = 1'b1;
      send_bit = 1'b1;
      case (state)
         ST_READ, ST_SBIT: send_bit = cur;
         ST_SCMP:          send_bit = ~cur;
         default:          sending  = 1'b0;
      endcase
   end

   function automatic ow_state_e decode(input logic [7:0] op);
      if (op == OP_READ_A || op == OP_READ_B) return ST_READ;
      else if (op == OP_SEARCH)               return ST_SBIT;
      else                                    return ST_SILENT;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_q <= 1'b1;
      else        bus_q <= bus_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_SILENT;
         tmr        <= '0;
         in_slot    <= 1'b0;
         bit_idx    <= '0;
         cmd        <= '0;
         bus_pull_o <= 1'b0;
      end else if (rst_det) begin
         state      <= ST_PWAIT;
         tmr        <= '0;
         in_slot    <= 1'b0;
         bit_idx    <= '0;
         bus_pull_o <= 1'b0;
      end else begin
         if (tick && tmr != '1) tmr <= tmr + 1'b1;
         case (state)
            ST_SILENT: ;
            ST_PWAIT: if (tmr >= TW'(PDH_US)) begin
               state      <= ST_PDRV;
               tmr        <= '0;
               bus_pull_o <= 1'b1;
            end
            ST_PDRV: if (tmr >= TW'(PDL_US)) begin
               state      <= ST_CMD;
               bus_pull_o <= 1'b0;
               bit_idx    <= '0;
            end
            default: begin
               if (!in_slot) begin
                  if (fall) begin
                     in_slot    <= 1'b1;
                     tmr        <= '0;
                     bus_pull_o <= sending & ~send_bit;
                  end
               end else begin
                  if (tmr >= TW'(HOLD_US)) bus_pull_o <= 1'b0;
                  if (tmr >= TW'(SAMPLE_US)) begin
                     in_slot <= 1'b0;
                     case (state)
                        ST_CMD: begin
                           cmd <= {bus_s, cmd[6:1]};
                           if (bit_idx == 6'd7) begin
                              bit_idx <= '0;
                              state   <= decode({bus_s, cmd});
                           end else begin
                              bit_idx <= bit_idx + 1'b1;
                           end
                        end
                        ST_READ: begin
                           if (bit_idx == 6'd63) state <= ST_SILENT;
                           else                  bit_idx <= bit_idx + 1'b1;
                        end
                        ST_SBIT: state <= ST_SCMP;
                        ST_SCMP: state <= ST_SWR;
                        ST_SWR: begin
                           if (bus_s != cur || bit_idx == 6'd63) begin
                              state <= ST_SILENT;
                           end else begin
                              bit_idx <= bit_idx + 1'b1;
                              state   <= ST_SBIT;
                           end
                        end
                        default: ;
                     endcase
                  end
               end
            end
         endcase
      end
   end

   AST_PWAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PWAIT) |-> !bus_pull_o); // R2
   AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {ST_CMD, ST_SWR}) |-> !bus_pull_o); // R3
   AST_READ_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ && bus_pull_o) |-> !cur); // R4
   AST_SEARCH_CMP_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCMP && bus_pull_o) |-> cur); // R5
   AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SILENT) |-> !bus_pull_o); // R6
   AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_pull_o && state != ST_PDRV) |-> in_slot); // R7
   AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_det |=> (state == ST_PWAIT && !bus_pull_o)); // R8

endmodule

// File: tb/ow_serial_id_bench.sv
`timescale 1ns/1ps
module ow_serial_id_bench;

   localparam int          CPU  = 2;
   localparam logic [7:0]  FAM  = 8'h01;
   localparam logic [47:0] SER  = 48'h5A3C_96E1_0F72;
   localparam logic [7:0]  CHK  = 8'hB4;
   localparam logic [63:0] ID   = {CHK, SER, FAM};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic pull;
   wire  line = ~(m_low | pull);

   always #10 clk = ~clk;

   ow_serial_id #(.CLK_PER_US(CPU), .FAMILY(FAM), .SERIAL(SER), .CRC(CHK))
      u_ow_serial_id (.clk(clk), .rst_n(rst_n), .bus_i(line), .bus_pull_o(pull));

   int    n_chk = 0;
   int    n_fail = 0;
   logic  care = 1'b0;
   logic  exp_pull = 1'b0;
   string req = "";

   // per-clock comparison against the behavioural expectation
   always @(posedge clk) begin
      #5;
      if (care) begin
         n_chk++;
         if (pull !== exp_pull) begin
            n_fail++;
            $display("FAIL %s: pull=%0b expected=%0b at %0t", req, pull, exp_pull, $time);
         end
      end
   end

   task automatic us(input int n);
      repeat (n * CPU) @(negedge clk);
   endtask

   task automatic expect_pull(input bit c, input bit v, input string r);
      care = c; exp_pull = v; req = r;
   endtask

   task automatic check(input bit act, input bit expv, input string r);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: got=%0b expected=%0b at %0t", r, act, expv, $time);
      end
   endtask

   task automatic bus_reset(input string r);
      expect_pull(0, 0, r); m_low = 1'b1; us(20);
      expect_pull(1, 0, r); us(480);
      m_low = 1'b0;
      expect_pull(0, 0, r); us(3);
      expect_pull(1, 0, r); us(24);
      expect_pull(0, 0, r); us(8);
      expect_pull(1, 1, r); us(55);
      check(line, 1'b0, {r, " presence level"});
      us(55);
      expect_pull(0, 0, r); us(10);
      expect_pull(1, 0, r); us(148);
   endtask

   task automatic write_bit(input bit b, input string r);
      expect_pull(1, 0, r);
      m_low = 1'b1; us(b ? 5 : 70);
      m_low = 1'b0; us(b ? 75 : 10);
   endtask

   task automatic write_byte(input logic [7:0] v, input string r);
      for (int i = 0; i < 8; i++) write_bit(v[i], r);
   endtask

   task automatic read_bit(input bit active, input bit b, input string r);
      expect_pull(0, 0, r); m_low = 1'b1; us(2);
      m_low = 1'b0; us(2);
      expect_pull(1, active & ~b, r); us(6);
      check(line, active ? b : 1'b1, r);
      us(2);
      expect_pull(0, 0, r); us(8);
      expect_pull(1, 0, r); us(60);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      check(pull, 1'b0, "R9 reset state");
      rst_n = 1'b1;
      expect_pull(1, 0, "R9"); us(50);
      read_bit(0, 1, "R9 before first bus reset");
      read_bit(0, 1, "R9 before first bus reset");

      // full read with 33h
      bus_reset("R1 R2");
      write_byte(8'h33, "R3");
      for (int i = 0; i < 64; i++) read_bit(1, ID[i], "R4 read 33h");
      read_bit(0, 1, "R4 after bit 63");

      // alternate opcode, then abort mid-stream
      bus_reset("R2");
      write_byte(8'h0F, "R3");
      for (int i = 0; i < 16; i++) read_bit(1, ID[i], "R4 read 0Fh");
      bus_reset("R8 abort");
      write_byte(8'h33, "R8");
      for (int i = 0; i < 8; i++) read_bit(1, ID[i], "R8 restart");

      // full search
      bus_reset("R5");
      write_byte(8'hF0, "R5");
      for (int i = 0; i < 64; i++) begin
         read_bit(1, ID[i], "R5 true bit");
         read_bit(1, ~ID[i], "R5 complement");
         write_bit(ID[i], "R5");
      end
      read_bit(0, 1, "R5 after search");

      // search lost at bit 10
      bus_reset("R5");
      write_byte(8'hF0, "R5");
      for (int i = 0; i < 10; i++) begin
         read_bit(1, ID[i], "R5 true bit");
         read_bit(1, ~ID[i], "R5 complement");
         write_bit(ID[i], "R5");
      end
      read_bit(1, ID[10], "R5 true bit");
      read_bit(1, ~ID[10], "R5 complement");
      write_bit(~ID[10], "R5 mismatch");
      for (int k = 0; k < 3; k++) read_bit(0, 1, "R5 dropped out");

      // rejected commands
      bus_reset("R6"); write_byte(8'h55, "R6");
      for (int k = 0; k < 3; k++) read_bit(0, 1, "R6 55h");
      bus_reset("R6"); write_byte(8'hCC, "R6");
      for (int k = 0; k < 3; k++) read_bit(0, 1, "R6 CCh");
      bus_reset("R6"); write_byte(8'hA5, "R6");
      for (int k = 0; k < 3; k++) read_bit(0, 1, "R6 A5h");

      // low shorter than a reset
      expect_pull(1, 0, "R1 short low");
      m_low = 1'b1; us(200);
      m_low = 1'b0; us(200);
      read_bit(0, 1, "R1 no presence");

      expect_pull(0, 0, "");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule